// File: doc/BRIEF.md
# PDM Microphone Decimator

This block drives the bit clock of a MEMS microphone whose output is a pulse-density-modulated (PDM) one-bit stream. It turns that stream into signed PCM samples. A fast system clock is divided by a programmable integer period to make the microphone clock. Settings outside the legal microphone clock range are clamped to the nearest legal period. The data line is passed through a synchronizer and captured once per microphone clock period, in the system cycle just before the next rising edge.

Each captured bit counts as +1 for a one and -1 for a zero. The bit is weighted by a coefficient chosen by its position in a window of `WIN` microphone periods (64 by default), and the weighted values are summed. At the end of every window the sum is presented on `pcm_out` with a one-cycle `pcm_valid` strobe. The accumulator then starts the next window from zero. Dense ones give a large positive sample, sparse ones a large negative sample, and an even mix gives a value near zero. The output rate is the microphone clock rate divided by `WIN`, so a 3.072 MHz bit clock with a window of 64 gives 48 kHz samples.

With the default parameters the system clock is taken as 100 MHz. The legal microphone periods are then 21 to 250 system cycles, which gives 4.76 MHz to 400 kHz. The coefficients form a symmetric triangle whose weights sum to 1056, and `pcm_out` is 12 bits signed.

Top module: `pdm_decim`

## Requirements
- R1: `mic_clk` has a period of exactly P system cycles and is high for floor(P/2) of them, where P is the clamped value of `div_sel`.
- R2: A `div_sel` below 21 gives P = 21, a value above 250 gives P = 250, and values from 21 to 250 are used as given (8-bit `div_sel`, default parameters).
- R3: While `rst` is held, `mic_clk` stays low, `pcm_valid` stays low and `pcm_out` reads 0.
- R4: Exactly one data bit is taken per microphone period. It is the level that `pdm_data` holds from three system cycles after a rising edge of `mic_clk` up to the next rising edge. That bit is credited to the period which that next rising edge closes.
- R5: The bit of the k-th period of a window (k = 0..63, counting from the first rising edge after reset) adds +w(k) when it is 1 and -w(k) when it is 0, where w(k) = min(k+1, 64-k).
- R6: An all-ones window yields +1056 and an all-zeros window yields -1056, with no wrap in the 12-bit two's-complement output.
- R7: `pcm_valid` is high for a single system cycle. It is high in the same cycle as the rising edge of `mic_clk` that closes the 64th period of a window, and it is never high at any other time.
- R8: Every window starts from zero, so a sample depends only on the 64 bits of its own window, even when the windows are back to back.
- R9: A reset in the middle of a window discards the partial sum. After the reset is released, the first `pcm_valid` appears only when a complete fresh window of 64 periods has been collected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | DIV_W (8) | Requested microphone clock period in system cycles, clamped to the legal range |
| mic_clk | output | 1 | Bit clock driven to the microphone (registered) |
| pdm_data | input | 1 | One-bit PDM stream from the microphone, asynchronous |
| pcm_out | output | PCM_W (12) | Signed PCM sample, held between strobes |
| pcm_valid | output | 1 | One-cycle strobe marking a new `pcm_out` value |

## Verification
The bench goes after the position-to-weight mapping with patterns whose sums are known by hand. All ones and all zeros check the full-scale ends. A lead of sixteen ones must give -784, so a mirrored, shifted or flat table shows up as a wrong number. Alternating bits must sum to zero, which catches any error in the ±1 mapping or the window alignment. The clamp is driven at 0, 5 and 255, where a missing clamp would give a period that is too short or too long. A reset part-way through a window checks that the partial sum is discarded: a design that kept it would strobe early or deliver a polluted sample. The same test catches a design that starts the count late. Windows run back to back with the pattern switching between ones and zeros, so an accumulator that failed to clear would carry the previous window's sum into the next sample.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

   // Coefficient shape selectors
   localparam int SHAPE_TRI  = 0;
   localparam int SHAPE_FLAT = 1;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // Triangular weight for window position pos
   function automatic int tri_weight(input int pos, input int win);
      int up;
      int down;
      up   = pos + 1;
      down = win - pos;
      return (up < down) ? up : down;
   endfunction

   function automatic int coef_at(input int pos, input int win, input int shape);
      return (shape == SHAPE_TRI) ? tri_weight(pos, win) : 1;
   endfunction

   function automatic int coef_peak(input int win, input int shape);
      return (shape == SHAPE_TRI) ? (win + 1) / 2 : 1;
   endfunction

   function automatic int coef_total(input int win, input int shape);
      int acc;
      acc = 0;
      for (int p = 0; p < win; p++) acc += coef_at(p, win, shape);
      return acc;
   endfunction

   // Signed width holding +/- the full coefficient total
   function automatic int pcm_width(input int win, input int shape);
      return $clog2(coef_total(win, shape) + 1) + 1;
   endfunction

endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
   parameter int PW   = 8,
   parameter int PMIN = 21,
   parameter int PMAX = 250
)(
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] div_sel,
   output logic          mic_clk,
   output logic          take
);
   logic [PW-1:0] per_in;
   logic [PW-1:0] per_q,  per_nxt;
   logic [PW-1:0] cnt_q,  cnt_nxt;
   logic          run_q;
   logic          mic_q;

   // Clamp the requested period into the legal range
   always_comb begin
      if (div_sel < PW'(PMIN))      per_in = PW'(PMIN);
      else if (div_sel > PW'(PMAX)) per_in = PW'(PMAX);
      else                          per_in = div_sel;
   end

   // Last system cycle of a period: the bit is taken here
   assign take = run_q && (cnt_q == per_q - PW'(1));

   always_comb begin
      per_nxt = per_q;
      cnt_nxt = cnt_q + PW'(1);
      if (!run_q) begin
         cnt_nxt = '0;
      end else if (take) begin
         cnt_nxt = '0;
         per_nxt = per_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         per_q <= per_in;
         mic_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         cnt_q <= cnt_nxt;
         per_q <= per_nxt;
         mic_q <= (cnt_nxt < (per_nxt >> 1));
      end
   end

   assign mic_clk = mic_q;

endmodule

// File: rtl/pdm_sync.sv
module pdm_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic d_sync
);
   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= d_async;
         end
         assign d_sync = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], d_async};
         end
         assign d_sync = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pdm_coef.sv
module pdm_coef
   import pdm_pkg::*;
#(
   parameter int WIN   = 64,
   parameter int SHAPE = SHAPE_TRI,
   parameter int IDX_W = $clog2(WIN),
   parameter int WW    = $clog2(coef_peak(WIN, SHAPE) + 1)
)(
   input  logic [IDX_W-1:0] idx,
   output logic [WW-1:0]    weight
);
   generate
      if (SHAPE == SHAPE_TRI) begin : g_tri
         logic [WW-1:0] tbl [WIN];
         for (genvar g = 0; g < WIN; g++) begin : g_ent
            assign tbl[g] = WW'(tri_weight(g, WIN));
         end
         assign weight = tbl[idx];
      end else begin : g_flat
         logic [IDX_W-1:0] idx_unused;
         assign idx_unused = idx;
         assign weight     = WW'(1);
      end
   endgenerate

endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
   parameter int WIN   = 64,
   parameter int IDX_W = 6,
   parameter int WW    = 6,
   parameter int ACC_W = 12
)(
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    take,
   input  logic                    bit_in,
   input  logic [WW-1:0]           weight,
   output logic [IDX_W-1:0]        idx,
   output logic signed [ACC_W-1:0] pcm_out,
   output logic                    pcm_valid
);
   logic [IDX_W-1:0]        idx_q;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] wext;
   logic signed [ACC_W-1:0] term;
   logic signed [ACC_W-1:0] pcm_q;
   logic                    vld_q;
   logic                    last;

   assign wext = signed'(ACC_W'(weight));
   assign term = bit_in ? wext : -wext;
   assign last = (idx_q == IDX_W'(WIN - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
         acc_q <= '0;
         pcm_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (take) begin
            if (last) begin
               pcm_q <= acc_q + term;
               vld_q <= 1'b1;
               acc_q <= '0;
               idx_q <= '0;
            end else begin
               acc_q <= acc_q + term;
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   assign idx       = idx_q;
   assign pcm_out   = pcm_q;
   assign pcm_valid = vld_q;

endmodule

// File: rtl/pdm_decim.sv
module pdm_decim
   import pdm_pkg::*;
#(
   parameter int SYS_HZ      = 100_000_000,
   parameter int MIC_MIN_HZ  = 400_000,
   parameter int MIC_MAX_HZ  = 4_800_000,
   parameter int WIN         = 64,
   parameter int SHAPE       = SHAPE_TRI,
   parameter int SYNC_STAGES = 2,
   parameter int PER_MAX     = SYS_HZ / MIC_MIN_HZ,
   parameter int DIV_W       = $clog2(PER_MAX + 1),
   parameter int PCM_W       = pcm_width(WIN, SHAPE)
)(
   input  logic                    clk,
   input  logic                    rst,
   input  logic [DIV_W-1:0]        div_sel,
   output logic                    mic_clk,
   input  logic                    pdm_data,
   output logic signed [PCM_W-1:0] pcm_out,
   output logic                    pcm_valid
);
   localparam int PER_MIN = ceil_div(SYS_HZ, MIC_MAX_HZ);
   localparam int IDX_W   = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int WW      = $clog2(coef_peak(WIN, SHAPE) + 1);

   // Elaboration-time parameter checks
   generate
      if (WIN < 2) begin : g_bad_win
         $error("WIN must be at least 2");
      end
      if (SHAPE != SHAPE_TRI && SHAPE != SHAPE_FLAT) begin : g_bad_shape
         $error("SHAPE selects an unknown coefficient variant");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (PER_MIN > PER_MAX) begin : g_bad_range
         $error("legal microphone clock range is empty");
      end
      if (PER_MIN < SYNC_STAGES + 3) begin : g_bad_fast
         $error("shortest period too short for the synchronizer");
      end
      if (PCM_W <= WW) begin : g_bad_width
         $error("PCM width must exceed weight width");
      end
   endgenerate

   logic             take;
   logic             bit_s;
   logic [IDX_W-1:0] idx;
   logic [WW-1:0]    weight;

   pdm_clkgen #(
      .PW  (DIV_W),
      .PMIN(PER_MIN),
      .PMAX(PER_MAX)
   ) clkgen_i (
      .clk    (clk),
      .rst    (rst),
      .div_sel(div_sel),
      .mic_clk(mic_clk),
      .take   (take)
   );

   pdm_sync #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst    (rst),
      .d_async(pdm_data),
      .d_sync (bit_s)
   );

   pdm_coef #(
      .WIN  (WIN),
      .SHAPE(SHAPE),
      .IDX_W(IDX_W),
      .WW   (WW)
   ) coef_i (
      .idx   (idx),
      .weight(weight)
   );

   pdm_accum #(
      .WIN  (WIN),
      .IDX_W(IDX_W),
      .WW   (WW),
      .ACC_W(PCM_W)
   ) accum_i (
      .clk      (clk),
      .rst      (rst),
      .take     (take),
      .bit_in   (bit_s),
      .weight   (weight),
      .idx      (idx),
      .pcm_out  (pcm_out),
      .pcm_valid(pcm_valid)
   );

endmodule

// File: rtl/pdm_decim_chk.sv
module pdm_decim_chk
   import pdm_pkg::*;
#(
   parameter int WIN   = 64,
   parameter int SHAPE = SHAPE_TRI,
   parameter int PCM_W = 12
)(
   input logic                    clk,
   input logic                    rst,
   input logic                    mic_clk,
   input logic                    pcm_valid,
   input logic signed [PCM_W-1:0] pcm_out
);
   localparam int FULL = coef_total(WIN, SHAPE);

   // R3: one clock into reset the outputs are idle
   p_idle_in_reset_r3: assert property (@(posedge clk)
      rst |=> (!mic_clk && !pcm_valid && pcm_out == '0));

   // R7: strobe lasts one cycle
   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      pcm_valid |=> !pcm_valid);

   // R7: strobe coincides with a rising microphone clock edge
   p_rise_aligned_r7: assert property (@(posedge clk) disable iff (rst)
      pcm_valid |-> $rose(mic_clk));

   // R6: samples stay within the full-scale sum
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      pcm_valid |-> (pcm_out <= FULL && pcm_out >= -FULL));

   // R8: sample is held between strobes
   p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
      !pcm_valid |-> $stable(pcm_out));

endmodule

bind pdm_decim pdm_decim_chk #(
   .WIN  (WIN),
   .SHAPE(SHAPE),
   .PCM_W(PCM_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .mic_clk  (mic_clk),
   .pcm_valid(pcm_valid),
   .pcm_out  (pcm_out)
);

// File: tb/pdm_decim_tb_top.sv
`timescale 1ns/1ps
module pdm_decim_tb_top;
   localparam int WIN  = 64;
   localparam int PMIN = 21;
   localparam int PMAX = 250;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [7:0]        div_sel = 8'd5;
   logic              pdm_data = 1'b0;
   logic              mic_clk;
   logic              pcm_valid;
   logic signed [11:0] pcm_out;

   always #4 clk = ~clk;

   pdm_decim dut_i (
      .clk      (clk),
      .rst      (rst),
      .div_sel  (div_sel),
      .mic_clk  (mic_clk),
      .pdm_data (pdm_data),
      .pcm_out  (pcm_out),
      .pcm_valid(pcm_valid)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   int    exp_per = PMIN;
   string per_req = "R1";
   string val_req = "R6";
   int    mode = 0;          // 0 ones, 1 zeros, 2 alternating, 3 lfsr, 4 lead16
   int    n_valid_seen = 0;
   int    last_pcm = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int wgt(input int k);
      return (k + 1 < WIN - k) ? k + 1 : WIN - k;
   endfunction

   function automatic int clampv(input int d);
      if (d < PMIN) return PMIN;
      if (d > PMAX) return PMAX;
      return d;
   endfunction

   // Reference model, compared at every falling edge
   initial begin
      bit seen_first = 1'b0;
      bit prev_mic   = 1'b0;
      bit rst_prev   = 1'b1;
      int pos = 0, acc = 0, cyc = 0, hi = 0;
      forever begin
         @(negedge clk);
         if (rst) begin
            if (rst_prev) begin
               chk(!mic_clk, "R3", "mic_clk in reset", int'(mic_clk), 0);
               chk(!pcm_valid, "R3", "pcm_valid in reset", int'(pcm_valid), 0);
               chk(pcm_out == 0, "R3", "pcm_out in reset", int'(pcm_out), 0);
            end
            seen_first = 1'b0; prev_mic = 1'b0;
            pos = 0; acc = 0; cyc = 0; hi = 0;
         end else begin
            bit rise, fall, exp_v;
            int exp_val;
            rise  = mic_clk && !prev_mic;
            fall  = !mic_clk && prev_mic;
            exp_v = 1'b0;
            exp_val = 0;
            cyc++;
            if (mic_clk) hi++;
            if (rise && seen_first) begin
               acc += pdm_data ? wgt(pos) : -wgt(pos);
               if (pos == WIN - 1) begin
                  exp_v = 1'b1; exp_val = acc; acc = 0; pos = 0;
               end else pos++;
               chk(cyc == exp_per, per_req, "mic_clk period", cyc, exp_per);
            end
            if (fall && seen_first) begin
               chk(hi == exp_per / 2, per_req, "mic_clk high time", hi, exp_per / 2);
               hi = 0;
            end
            if (rise) begin
               cyc = 0;
               if (!seen_first) hi = 1;
            end
            chk(pcm_valid == exp_v, "R7", "pcm_valid", int'(pcm_valid), int'(exp_v));
            if (exp_v) begin
               chk(int'(pcm_out) == exp_val, val_req, "pcm_out", int'(pcm_out), exp_val);
               last_pcm = int'(pcm_out);
               n_valid_seen++;
            end
            if (rise) begin
               seen_first = 1'b1;
               // drive the bit for window position pos
               case (mode)
                  0: pdm_data = 1'b1;
                  1: pdm_data = 1'b0;
                  2: pdm_data = (pos % 2 == 0);
                  3: begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        pdm_data = lfsr[0];
                     end
                  default: pdm_data = (pos < 16);
               endcase
            end
            prev_mic = mic_clk;
         end
         rst_prev = rst;
      end
   end

   task automatic wait_valids(input int n);
      int target;
      target = n_valid_seen + n;
      while (n_valid_seen < target) @(posedge clk);
   endtask

   task automatic do_reset(input int d, input string preq);
      @(posedge clk); #1;
      rst = 1'b1;
      div_sel = 8'(d);
      exp_per = clampv(d);
      per_req = preq;
      repeat (5) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R2 low clamp, R6 full scale positive
      mode = 0; val_req = "R6";
      do_reset(5, "R2");
      wait_valids(2);
      chk(last_pcm == 1056, "R6", "all ones sample", last_pcm, 1056);
      // R8 back-to-back windows after ones
      mode = 1; val_req = "R8";
      wait_valids(2);
      chk(last_pcm == -1056, "R6", "all zeros sample", last_pcm, -1056);
      // R5 position weighting
      mode = 2; val_req = "R5";
      wait_valids(2);
      chk(last_pcm == 0, "R5", "alternating sample", last_pcm, 0);
      mode = 4;
      wait_valids(2);
      chk(last_pcm == -784, "R5", "lead16 sample", last_pcm, -784);
      // R4 arbitrary stream
      mode = 3; val_req = "R4";
      wait_valids(3);
      // R9 reset part-way through a window
      repeat (700) @(posedge clk);
      do_reset(40, "R1");
      begin
         int waited;
         int target;
         waited = 0;
         target = n_valid_seen + 1;
         val_req = "R9";
         while (n_valid_seen < target) begin
            @(posedge clk);
            waited++;
         end
         chk(waited >= WIN * 40, "R9", "cycles to first sample", waited, WIN * 40);
      end
      wait_valids(1);
      // R2 high clamp
      mode = 0; val_req = "R6";
      do_reset(255, "R2");
      wait_valids(1);
      chk(last_pcm == 1056, "R6", "ones at slow clock", last_pcm, 1056);
      // R2 zero setting
      mode = 1;
      do_reset(0, "R2");
      wait_valids(1);
      chk(last_pcm == -1056, "R6", "zeros at fast clock", last_pcm, -1056);
      finish_run();
   end

endmodule